// File: doc/BRIEF.md
# Reconfigurable Signature Register

This block is a single n-bit register that can be switched, one clock at a time, between four jobs. It can hold zero, act as a plain serial scan path, run freely as a pseudo-random pattern source, or fold a stream of parallel response words into a signature. The feedback uses the internal-XOR (Galois) arrangement: the top stage is fed back into stage 0 and into every tapped stage. A compaction beat XORs each response bit into its own stage. When fewer response bits than stages are wired, the upper stages get no injection and only shift or take feedback.

A complete-sequence option for the generator adds the all-zero state to the sequence. The register then steps through all 2^n values in one period, which suits exhaustive address sweeps. A seed port loads any start value. A beat counter stops compaction after a programmable number of accepted beats and then holds the signature for readout.

Response words arrive over a valid/ready handshake. Ready is high only while the register is compacting, no seed load is pending and the beat budget is not used up. A word moves only on a cycle where valid and ready are both high. A source that sees ready low must hold its word and valid. The block never stores a word it did not accept.

Top module: `resp_sig_reg`

## Requirements
- R1: While reset is asserted and after it is released, the signature is 0 and the beat count is 0; done is 0 whenever the beat budget is non-zero.
- R2: Mode 2'b00 (clear) sets the signature and the beat count to 0 on the next clock.
- R3: Mode 2'b01 (shift) moves every stage one place toward the most significant bit and loads the serial input into bit 0; the serial output always equals the most significant bit.
- R4: Mode 2'b10 (generate) applies one Galois step per clock. The top bit is fed back into bit 0 and XORed into each bit i with TAPS[i] set (default TAPS = 8'h1C, polynomial x^8+x^4+x^3+x^2+1). The response input is ignored, ready stays low, and from a non-zero seed the period is 2^n-1.
- R5: Mode 2'b11 (compact) on an accepted beat gives the next signature as the Galois step XOR the response word. Bit i of the word goes into stage i. On a cycle with valid low the signature holds.
- R6: Only stages 0 to NUM_IN-1 receive response bits; stages NUM_IN and up take only shift and feedback.
- R7: In generate mode with the complete option set, the feedback is XORed with the NOR of all stages below the top. The sequence then visits zero exactly once and has period 2^n. From zero the next state is TAPS with bit 0 set.
- R8: A seed load loads the seed value and clears the beat count, whatever the mode.
- R9: Once the accepted-beat count reaches the budget, done is high, ready is low and the signature stays frozen in compact mode until a clear or a seed load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 clear, 01 shift, 10 generate, 11 compact |
| complete_i | input | 1 | Insert the all-zero state in generate mode |
| seed_load_i | input | 1 | Load seed_i this clock, clear beat count |
| seed_i | input | WIDTH | Seed value |
| resp_data_i | input | NUM_IN | Parallel response word |
| resp_valid_i | input | 1 | Response word valid |
| resp_ready_o | output | 1 | Register will accept the word this clock |
| ser_in_i | input | 1 | Serial scan input into bit 0 |
| ser_out_o | output | 1 | Serial scan output, the top bit |
| compact_len_i | input | CNT_W | Number of beats to compact before done |
| done_o | output | 1 | Beat budget reached, signature frozen |
| signature_o | output | WIDTH | Register contents |

## Verification
Every signature change lands on the rising edge after the inputs that cause it. The driver sets the inputs half a cycle earlier and, just after that edge, pushes the value a reference model predicts. The monitor pops and compares signature, serial output and done at the next falling edge. Ready is combinational from the current inputs and beat count, so the driver checks it in the same cycle, before the edge. The period checks count steps on the sampled signature until the seed comes back, and they also count how often zero appears.

// File: rtl/resp_sig_pkg.sv
package resp_sig_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR   = 2'b00,
    MODE_SHIFT   = 2'b01,
    MODE_GEN     = 2'b10,
    MODE_COMPACT = 2'b11
  } sig_mode_e;
endpackage

// File: rtl/rsr_galois_step.sv
// One internal-XOR LFSR step, with optional all-zero insertion.
module rsr_galois_step #(
  parameter int          WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'h1C
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             complete_i,
  output logic [WIDTH-1:0] next_o
);
  logic low_zero;
  logic fb;

  assign low_zero = ~|state_i[WIDTH-2:0];
  assign fb       = state_i[WIDTH-1] ^ (complete_i & low_zero);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign next_o[i] = fb;
    end else if (TAPS[i]) begin : g_tap
      assign next_o[i] = state_i[i-1] ^ fb;
    end else begin : g_plain
      assign next_o[i] = state_i[i-1];
    end
  end
endmodule

// File: rtl/rsr_inject.sv
// XOR the response word into the low NUM_IN stages only.
module rsr_inject #(
  parameter int WIDTH  = 8,
  parameter int NUM_IN = 6
) (
  input  logic [WIDTH-1:0]  base_i,
  input  logic [NUM_IN-1:0] data_i,
  output logic [WIDTH-1:0]  out_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < NUM_IN) begin : g_xor
      assign out_o[i] = base_i[i] ^ data_i[i];
    end else begin : g_pass
      assign out_o[i] = base_i[i];
    end
  end
endmodule

// File: rtl/rsr_beat_counter.sv
// Counts accepted compaction beats against a budget.
module rsr_beat_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (beat_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R9
  beat_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !clear_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/resp_sig_reg.sv
module resp_sig_reg #(
  parameter int               WIDTH  = 8,
  parameter int               NUM_IN = 6,
  parameter logic [WIDTH-1:0] TAPS   = 8'h1C,
  parameter int               CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              complete_i,
  input  logic              seed_load_i,
  input  logic [WIDTH-1:0]  seed_i,
  input  logic [NUM_IN-1:0] resp_data_i,
  input  logic              resp_valid_i,
  output logic              resp_ready_o,
  input  logic              ser_in_i,
  output logic              ser_out_o,
  input  logic [CNT_W-1:0]  compact_len_i,
  output logic              done_o,
  output logic [WIDTH-1:0]  signature_o
);
  import resp_sig_pkg::*;

  localparam logic [WIDTH-1:0] ZERO_NEXT = TAPS | WIDTH'(1);

  sig_mode_e        mode;
  logic [WIDTH-1:0] state_q, state_d;
  logic [WIDTH-1:0] gen_next, cmp_base, cmp_next;
  logic             accept, count_clear, done;

  assign mode = sig_mode_e'(mode_i);

  rsr_galois_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_gen_step (
    .state_i(state_q), .complete_i(complete_i), .next_o(gen_next)
  );

  rsr_galois_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_cmp_step (
    .state_i(state_q), .complete_i(1'b0), .next_o(cmp_base)
  );

  rsr_inject #(.WIDTH(WIDTH), .NUM_IN(NUM_IN)) u_inject (
    .base_i(cmp_base), .data_i(resp_data_i), .out_o(cmp_next)
  );

  assign count_clear = seed_load_i || (mode == MODE_CLEAR);

  rsr_beat_counter #(.CNT_W(CNT_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .clear_i(count_clear), .beat_i(accept),
    .len_i(compact_len_i), .done_o(done)
  );

  assign resp_ready_o = (mode == MODE_COMPACT) && !seed_load_i && !done;
  assign accept       = resp_ready_o && resp_valid_i;

  always_comb begin
    state_d = state_q;
    if (seed_load_i) begin
      state_d = seed_i;
    end else begin
      unique case (mode)
        MODE_CLEAR:   state_d = '0;
        MODE_SHIFT:   state_d = {state_q[WIDTH-2:0], ser_in_i};
        MODE_GEN:     state_d = gen_next;
        MODE_COMPACT: if (accept) state_d = cmp_next;
        default:      state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign signature_o = state_q;
  assign ser_out_o   = state_q[WIDTH-1];
  assign done_o      = done;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !seed_load_i) |=> (signature_o == '0));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && !seed_load_i) |=>
      (signature_o == {$past(signature_o[WIDTH-2:0]), $past(ser_in_i)}));

  // R4
  gen_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10) |-> !resp_ready_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !seed_load_i && !resp_valid_i) |=> $stable(signature_o));

  // R7
  zero_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && complete_i && !seed_load_i && signature_o == '0)
      |=> (signature_o == ZERO_NEXT));

  // R8
  seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> (signature_o == $past(seed_i)));

  // R9
  frozen_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_i == 2'b11 && !seed_load_i) |=> $stable(signature_o));

  // R9
  no_ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready_o |-> !done_o);
endmodule

// File: tb/resp_sig_reg_tb_top.sv
`timescale 1ns/1ps
module resp_sig_reg_tb_top;
  localparam int          W   = 8;
  localparam int          NI  = 6;
  localparam int          CW  = 6;
  localparam logic [7:0]  TP  = 8'h1C;

  typedef struct {
    logic [W-1:0] sig;
    logic         done;
    logic         so;
    string        tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic cpl = 1'b0, sl = 1'b0, valid = 1'b0, si = 1'b0;
  logic [W-1:0] seed = '0;
  logic [NI-1:0] data = '0;
  logic [CW-1:0] len = 6'd4;
  logic ready, so, done;
  logic [W-1:0] sig;

  int checks = 0, fails = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [W-1:0] m_sig = '0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  resp_sig_reg #(.WIDTH(W), .NUM_IN(NI), .TAPS(TP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .complete_i(cpl),
    .seed_load_i(sl), .seed_i(seed), .resp_data_i(data),
    .resp_valid_i(valid), .resp_ready_o(ready), .ser_in_i(si),
    .ser_out_o(so), .compact_len_i(len), .done_o(done), .signature_o(sig)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mstep(input logic [W-1:0] s, input logic c);
    logic f;
    f = s[W-1] ^ (c && (s[W-2:0] == '0));
    return {s[W-2:0], 1'b0} ^ (f ? (TP | 8'h01) : 8'h00);
  endfunction

  // Driver: apply one cycle of stimulus and push the predicted result.
  task automatic step(input logic [1:0] m, input logic c, input logic l,
                      input logic [W-1:0] sd, input logic [NI-1:0] d,
                      input logic v, input logic s, input string tag);
    logic exp_ready;
    exp_t e;
    mode = m; cpl = c; sl = l; seed = sd; data = d; valid = v; si = s;
    exp_ready = (m == 2'b11) && !l && (m_cnt < int'(len));
    #1;
    check(ready == exp_ready, {tag, " ready"}, int'(ready), int'(exp_ready));
    if (l) begin
      m_sig = sd; m_cnt = 0;
    end else begin
      case (m)
        2'b00: begin m_sig = '0; m_cnt = 0; end
        2'b01: m_sig = {m_sig[W-2:0], s};
        2'b10: m_sig = mstep(m_sig, c);
        default: if (exp_ready && v) begin
          m_sig = mstep(m_sig, 1'b0) ^ {{(W-NI){1'b0}}, d};
          m_cnt++;
        end
      endcase
    end
    @(posedge clk); #1;
    e.sig = m_sig; e.done = (m_cnt >= int'(len)); e.so = m_sig[W-1]; e.tag = tag;
    sb.push_back(e);
    @(negedge clk); #0.5;
  endtask

  // Monitor: compare on the falling edge after each result edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(sig == e.sig, {e.tag, " signature"}, int'(sig), int'(e.sig));
      check(so == e.so, {e.tag, " serial out"}, int'(so), int'(e.so));
      check(done == e.done, {e.tag, " done"}, int'(done), int'(e.done));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int zeros;
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    check(sig == '0, "R1 sig in reset", int'(sig), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    check(sig == '0, "R1 sig after reset", int'(sig), 0);
    check(done == 1'b0 && ready == 1'b0, "R1 done/ready after reset", int'({done, ready}), 0);

    // R8 seed load, then R3 shift
    step(2'b11, 0, 1, 8'hA5, '0, 0, 0, "R8 seed");
    for (int i = 0; i < 10; i++) step(2'b01, 0, 0, '0, '0, 0, (i % 3) == 0, "R3 shift");

    // R4 generate ignores response input
    step(2'b00, 0, 1, 8'h5B, '0, 0, 0, "R8 seed gen");
    for (int i = 0; i < 20; i++) step(2'b10, 0, 0, '0, NI'(i * 7 + 3), 1, 0, "R4 gen");

    // R4 period 2^n-1 from seed 1
    step(2'b10, 0, 1, 8'h01, '0, 0, 0, "R8 seed 1");
    n = 0;
    do begin step(2'b10, 0, 0, '0, '0, 0, 0, "R4 period"); n++; end
    while (sig != 8'h01 && n < 400);
    check(n == 255, "R4 plain period", n, 255);

    // R7 complete period 2^n with one zero
    step(2'b10, 1, 1, 8'h01, '0, 0, 0, "R8 seed 1 cpl");
    n = 0; zeros = 0;
    do begin
      step(2'b10, 1, 0, '0, '0, 0, 0, "R7 complete");
      n++;
      if (sig == '0) zeros++;
    end while (sig != 8'h01 && n < 400);
    check(n == 256, "R7 complete period", n, 256);
    check(zeros == 1, "R7 zero visits", zeros, 1);

    // R2 clear
    step(2'b00, 0, 0, '0, '0, 0, 0, "R2 clear");

    // R5 R6 compaction with gaps, R9 budget
    len = 6'd10;
    step(2'b11, 0, 1, 8'h3C, '0, 0, 0, "R8 seed compact");
    for (int i = 0; i < 16; i++)
      step(2'b11, 0, 0, '0, (i == 2) ? 6'h3F : NI'(i * 11 + 5), (i % 4) != 3, 0, "R5 R6 compact");
    for (int i = 0; i < 5; i++) step(2'b11, 0, 0, '0, 6'h2A, 1, 0, "R9 frozen");
    check(done == 1'b1, "R9 done high", int'(done), 1);

    // R8 seed load during compaction restarts the budget
    step(2'b11, 0, 1, 8'hC3, '0, 1, 0, "R8 reseed");
    for (int i = 0; i < 4; i++) step(2'b11, 0, 0, '0, NI'(i + 9), 1, 0, "R5 compact again");
    step(2'b00, 0, 0, '0, '0, 0, 0, "R2 clear after compact");

    // R9 zero budget: done at once, no beats taken
    len = 6'd0;
    step(2'b11, 0, 0, '0, 6'h15, 1, 0, "R9 zero budget");

    @(negedge clk); #0.5;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule